// File: doc/BRIEF.md
# Banked GPIO Expander Register File

This block is the register store of a GPIO expander with a parameterized number of lines, grouped into 8-bit ports. A serial-slave front end reaches it through a plain byte bus (address, write data, write strobe, read strobe, read data). The block keeps four banks: an input view of the pins, the output values, a per-bit polarity invert, and the line direction. Each bank has one byte per port.

Bank spacing is the port count rounded up to a power of two. A register therefore sits at bank × spacing + port. The slots between the last port of a bank and the start of the next bank are empty. Raw pin samples pass through a two-flop synchronizer. The input bank shows them with the invert bits applied. The output register drives the pin values, and the direction register drives the output enables.

Top module: `gpx_regfile`

## Requirements
- R1: Bank order is fixed: bank index 0 = input, 1 = output, 2 = invert, 3 = direction. The byte of port p in bank b is at address b × spacing + p (with 24 lines, direction port 2 is 0x0E).
- R2: Spacing is the smallest power of two that is not below the port count: 1 for 4 or 8 lines, 2 for 16, 4 for 24 or 32, 8 for 40.
- R3: A read of an empty slot inside a bank, or of any address whose bank index is 4 or more, returns 0x00.
- R4: A write to an empty slot or an out-of-range address changes no register and no output.
- R5: The input bank is read-only. A write to it leaves every register and output unchanged.
- R6: An input-bank read returns the synchronized pin byte XOR the invert byte. A pin change made just before rising edge k is not seen by a read whose strobe is sampled on edge k+1, and is seen by one sampled on edge k+2.
- R7: gpio_oe[i] is 1 exactly when direction bit i is 0, and gpio_out[i] carries output register bit i. Both take a new value on the edge that accepts the write.
- R8: While reset is held (synchronous, active high), direction bits for implemented lines become 1 and the output and invert banks become 0, so gpio_oe is all 0 after reset.
- R9: A read of an output-bank register returns the stored value, whatever the pin level.
- R10: rd_data updates on the edge that samples rd_en high, and holds its value while rd_en is low.
- R11: When the line count is not a multiple of 8, the bits of the last port above the top line read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register byte address |
| wr_data | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| rd_data | output | 8 | Registered read data |
| pin_in | input | LINES | Raw asynchronous pin samples |
| gpio_out | output | LINES | Output values per line |
| gpio_oe | output | LINES | Output driver enable per line |

## Verification
The bench builds two copies on the same bus. One has 24 lines, which gives a spacing of 4, a hole at the end of every bank, and out-of-range addresses from 0x10. The other has 4 lines, which gives a spacing of 1 and a half-filled single port, so the unused upper bits can be checked. One write stream therefore lands as a real write on one copy and as an ignored or read-only write on the other. A pin change followed by back-to-back reads shows the exact synchronizer latency.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    typedef enum logic [1:0] {
        BANK_IN  = 2'd0,
        BANK_OUT = 2'd1,
        BANK_INV = 2'd2,
        BANK_DIR = 2'd3
    } bank_e;

    typedef struct packed {
        logic  hit;
        bank_e bank;
    } sel_t;

    // smallest power of two >= n (n >= 1)
    function automatic int unsigned ceil_pow2(input int unsigned n);
        int unsigned p;
        p = 1;
        for (int i = 0; i < 16; i++) begin
            if (p < n) p = p * 2;
        end
        return p;
    endfunction

    function automatic int unsigned log2_exact(input int unsigned n);
        int unsigned r;
        r = 0;
        for (int i = 0; i < 16; i++) begin
            if ((32'd1 << i) < n) r = i + 1;
        end
        return r;
    endfunction

    // implemented-line mask for one port byte
    function automatic logic [7:0] lane_mask(input int unsigned lines, input int unsigned port);
        logic [7:0] m;
        for (int b = 0; b < 8; b++) begin
            m[b] = ((port * 8 + b) < lines);
        end
        return m;
    endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;

    // warm-up counter so the two-cycle look-back never reaches into reset
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)            warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    p_two_stage_r6: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpx_addr_dec.sv
module gpx_addr_dec
    import gpx_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PORTS  = 3,
    parameter int SH     = 2,
    parameter int PIDX_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_t              sel,
    output logic [PIDX_W-1:0] port
);
    localparam int unsigned SPACING = 1 << SH;

    logic [ADDR_W-1:0] low;
    logic [ADDR_W-1:0] high;

    always_comb begin
        low      = addr & ADDR_W'(SPACING - 1);
        high     = addr >> SH;
        sel.hit  = (high < ADDR_W'(4)) && (low < ADDR_W'(PORTS));
        sel.bank = bank_e'(high[1:0]);
        port     = low[PIDX_W-1:0];
    end

endmodule

// File: rtl/gpx_bank.sv
module gpx_bank
    import gpx_pkg::*;
#(
    parameter int LINES    = 24,
    parameter int PORTS    = 3,
    parameter int PIDX_W   = 2,
    parameter bit RST_ONES = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PIDX_W-1:0] widx,
    input  logic [7:0]        wdata,
    output logic [PORTS*8-1:0] q
);
    for (genvar p = 0; p < PORTS; p++) begin : g_port
        localparam logic [7:0] MASK = lane_mask(LINES, p);
        always_ff @(posedge clk) begin
            if (rst)
                q[p*8 +: 8] <= RST_ONES ? MASK : 8'h00;
            else if (we && (widx == PIDX_W'(p)))
                q[p*8 +: 8] <= wdata & MASK;
        end
    end

endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
    import gpx_pkg::*;
#(
    parameter int LINES  = 24,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  gpio_out,
    output logic [LINES-1:0]  gpio_oe
);
    localparam int PORTS   = (LINES + 7) / 8;
    localparam int PW      = PORTS * 8;
    localparam int SPACING = ceil_pow2(PORTS);
    localparam int SH      = log2_exact(SPACING);
    localparam int PIDX_W  = (SH > 0) ? SH : 1;
    localparam int SLOTS   = 1 << PIDX_W;

    sel_t              sel;
    logic [PIDX_W-1:0] port;

    gpx_addr_dec #(.ADDR_W(ADDR_W), .PORTS(PORTS), .SH(SH), .PIDX_W(PIDX_W)) dec_i (
        .addr(addr), .sel(sel), .port(port)
    );

    logic [PW-1:0] out_q, inv_q, dir_q;
    logic we_out, we_inv, we_dir;

    assign we_out = wr_en && sel.hit && (sel.bank == BANK_OUT);
    assign we_inv = wr_en && sel.hit && (sel.bank == BANK_INV);
    assign we_dir = wr_en && sel.hit && (sel.bank == BANK_DIR);

    gpx_bank #(.LINES(LINES), .PORTS(PORTS), .PIDX_W(PIDX_W), .RST_ONES(1'b0)) out_bank_i (
        .clk(clk), .rst(rst), .we(we_out), .widx(port), .wdata(wr_data), .q(out_q));
    gpx_bank #(.LINES(LINES), .PORTS(PORTS), .PIDX_W(PIDX_W), .RST_ONES(1'b0)) inv_bank_i (
        .clk(clk), .rst(rst), .we(we_inv), .widx(port), .wdata(wr_data), .q(inv_q));
    gpx_bank #(.LINES(LINES), .PORTS(PORTS), .PIDX_W(PIDX_W), .RST_ONES(1'b1)) dir_bank_i (
        .clk(clk), .rst(rst), .we(we_dir), .widx(port), .wdata(wr_data), .q(dir_q));

    logic [LINES-1:0] pin_s;
    gpx_sync #(.W(LINES)) sync_i (.clk(clk), .rst(rst), .d(pin_in), .q(pin_s));

    logic [PW-1:0] in_view;
    assign in_view = PW'(pin_s) ^ inv_q;

    // byte views indexed by port slot; slots past the last port read zero
    logic [7:0] in_b  [SLOTS];
    logic [7:0] out_b [SLOTS];
    logic [7:0] inv_b [SLOTS];
    logic [7:0] dir_b [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        if (s < PORTS) begin : g_real
            assign in_b[s]  = in_view[s*8 +: 8];
            assign out_b[s] = out_q[s*8 +: 8];
            assign inv_b[s] = inv_q[s*8 +: 8];
            assign dir_b[s] = dir_q[s*8 +: 8];
        end else begin : g_hole
            assign in_b[s]  = 8'h00;
            assign out_b[s] = 8'h00;
            assign inv_b[s] = 8'h00;
            assign dir_b[s] = 8'h00;
        end
    end

    logic [7:0] rd_mux;
    always_comb begin
        rd_mux = 8'h00;
        if (sel.hit) begin
            unique case (sel.bank)
                BANK_IN:  rd_mux = in_b[port];
                BANK_OUT: rd_mux = out_b[port];
                BANK_INV: rd_mux = inv_b[port];
                BANK_DIR: rd_mux = dir_b[port];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= 8'h00;
        else if (rd_en) rd_data <= rd_mux;
    end

    assign gpio_out = out_q[LINES-1:0];
    assign gpio_oe  = ~dir_q[LINES-1:0];

    p_reset_state_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (gpio_oe == '0 && gpio_out == '0));

    p_miss_read_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !sel.hit) |=> (rd_data == 8'h00));

    p_miss_write_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !sel.hit) |=> ($stable(gpio_out) && $stable(gpio_oe) && $stable(inv_q)));

    p_input_readonly_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel.hit && sel.bank == BANK_IN) |=>
            ($stable(gpio_out) && $stable(gpio_oe) && $stable(inv_q)));

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

endmodule

// File: tb/gpx_regfile_tb_top.sv
module gpx_regfile_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst;
    logic [7:0]  addr;
    logic [7:0]  wr_data;
    logic        wr_en;
    logic        rd_en;
    logic [7:0]  rd_a, rd_b;
    logic [23:0] pin_a, out_a, oe_a;
    logic [3:0]  pin_b, out_b, oe_b;

    gpx_regfile #(.LINES(24), .ADDR_W(8)) dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
        .rd_en(rd_en), .rd_data(rd_a), .pin_in(pin_a), .gpio_out(out_a), .gpio_oe(oe_a));

    gpx_regfile #(.LINES(4), .ADDR_W(8)) dut_s (
        .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
        .rd_en(rd_en), .rd_data(rd_b), .pin_in(pin_b), .gpio_out(out_b), .gpio_oe(oe_b));

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [7:0] ea;
        logic [7:0] eb;
        string      tag;
    } item_t;
    item_t sb[$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // driver: one read per call, expected bytes for both copies
    task automatic rd(input logic [7:0] a, input logic [7:0] ea, input logic [7:0] eb, input string tag);
        item_t it;
        it.ea = ea; it.eb = eb; it.tag = tag;
        sb.push_back(it);
        addr  = a;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr    = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // monitor: a read strobed at an edge is compared on the following falling edge
    logic rd_seen = 1'b0;
    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb.size() == 0) begin
                check(1'b0, "scoreboard empty", 0, 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(rd_a === it.ea, {it.tag, " (24 lines)"}, rd_a, it.ea);
                check(rd_b === it.eb, {it.tag, " (4 lines)"}, rd_b, it.eb);
            end
        end
    end

    initial begin
        #1500000;
        check(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; addr = '0; wr_data = '0; wr_en = 1'b0; rd_en = 1'b0;
        pin_a = '0; pin_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8 reset values; R2 spacing 4 vs 1
        rd(8'h0C, 8'hFF, 8'h00, "R8 dir reset / R3 out of range");
        rd(8'h03, 8'h00, 8'h0F, "R8 dir reset (R2 spacing 1) / R3 hole");
        rd(8'h04, 8'h00, 8'h00, "R8 output reset");
        check(oe_a === 24'h0 && out_a === 24'h0, "R8 outputs after reset (24)", {oe_a, 8'h0}, 0);
        check(oe_b === 4'h0 && out_b === 4'h0, "R8 outputs after reset (4)", {oe_b, out_b}, 0);

        // R1 mapping
        wr(8'h05, 8'hA5);
        rd(8'h05, 8'hA5, 8'h00, "R1 output port1 at 0x05");
        wr(8'h0E, 8'h0F);
        wr(8'h06, 8'h3C);
        check(oe_a === 24'hF00000, "R7 oe from direction", oe_a, 24'hF00000);
        check(out_a === 24'h3CA500, "R7 out from output reg", out_a, 24'h3CA500);

        // R9 output read ignores pins
        pin_a = 24'h00FF00;
        rd(8'h06, 8'h3C, 8'h00, "R9 output read is register");

        // R3/R4 holes and out of range
        wr(8'h07, 8'h55);
        wr(8'h10, 8'h77);
        check(out_a === 24'h3CA500 && oe_a === 24'hF00000, "R4 ignored writes keep outputs", out_a, 24'h3CA500);
        rd(8'h07, 8'h00, 8'h00, "R3 hole read");
        rd(8'h04, 8'h00, 8'h00, "R4 port0 unchanged");
        rd(8'h05, 8'hA5, 8'h00, "R4 port1 unchanged");
        rd(8'h0D, 8'hFF, 8'h00, "R4 dir port1 unchanged");

        // R5 input read-only (24) / R11 upper bits (4)
        wr(8'h01, 8'hFA);
        check(out_b === 4'hA && oe_b === 4'h0, "R11 4-line out masked", {out_b, oe_b}, 8'hA0);
        check(out_a === 24'h3CA500, "R5 input write keeps outputs", out_a, 24'h3CA500);
        repeat (2) @(negedge clk);
        rd(8'h01, 8'hFF, 8'h0A, "R5 input unchanged / R11 upper bits zero");
        wr(8'h03, 8'h00);
        check(oe_b === 4'hF && out_b === 4'hA, "R7 4-line direction to outputs", {oe_b, out_b}, 8'hFA);
        rd(8'h03, 8'h00, 8'h00, "R1 dir read back");

        // R6 input view
        pin_a = 24'h123456; pin_b = 4'h9;
        repeat (3) @(negedge clk);
        rd(8'h00, 8'h56, 8'h09, "R6 input plain");
        rd(8'h02, 8'h12, 8'h00, "R6 input port2 / inv read");
        wr(8'h08, 8'hFF);
        wr(8'h02, 8'h03);
        rd(8'h00, 8'hA9, 8'h0A, "R6 input with invert");
        rd(8'h02, 8'h12, 8'h03, "R5 input readonly / R1 inv bank");

        // R6 synchronizer latency
        pin_a = 24'h123400; pin_b = 4'h0;
        rd(8'h00, 8'hA9, 8'h0A, "R6 latency edge+1 old");
        rd(8'h00, 8'hA9, 8'h0A, "R6 latency edge+2 old");
        rd(8'h00, 8'hFF, 8'h03, "R6 latency edge+3 new");

        // R10 hold
        repeat (4) @(negedge clk);
        check(rd_a === 8'hFF && rd_b === 8'h03, "R10 rd_data holds", {rd_a, rd_b}, 16'hFF03);
        check(sb.size() == 0, "scoreboard drained", sb.size(), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule